// File: doc/BRIEF.md
# Shared Interrupt Line Steering Router

This block takes eight shared, active-low, level-sensitive interrupt lines (A to H) and steers each one onto one input of a 16-input interrupt controller. Each line has its own 8-bit route register. The register either names a target IRQ number or turns steering off for that line. The block inverts each line to an active-high level. When several lines name the same IRQ, that IRQ stays asserted while any of them is low.

Two internal event sources feed into chosen lines before routing: a system-control event and a timer/watchdog event. Each one behaves as if its host line had been pulled low from outside. A separate 16-bit vector of directly driven active-high requests is ORed into the result.

Software must set the edge/level control of every IRQ that receives a steered line to level mode. This block does not do that.

Top module: `irq_steer_router`

## Requirements
- R1: After a synchronous reset, every route register reads 0x80. In that state `irq_req` equals `direct_irq` whatever the shared lines are doing.
- R2: A write at byte offset 0x60+n (n = 0..3) sets the route register of line n (A..D). A write at 0x68+n sets the register of line 4+n (E..H). A read at the same offset returns the full byte most recently written, whether or not that value is a valid route.
- R3: A write to any other offset changes no route register. A read of any other offset returns 0x00.
- R4: A line that is low drives `irq_req` bit T high, where T is bits 3:0 of its route register. This holds when bit 7 of the register is clear and T is in the allowed set.
- R5: A route register with bit 7 set drives no IRQ, whatever bits 3:0 hold.
- R6: The allowed targets are 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. A target of 0, 1, 2, 8 or 13 is treated as disabled. A steered line therefore never raises IRQ 0, 1, 2, 8 or 13.
- R7: When two or more asserted lines name the same target, that target is high. It stays high until every one of those lines is released.
- R8: Internal event 0 (system control, `evt_src[0]`) asserts line A. Internal event 1 (timer/watchdog, `evt_src[1]`) asserts line D. Each is then routed exactly like a low level on that pin.
- R9: Every bit set in `direct_irq` is set in `irq_req`, independent of routing.
- R10: Line levels, events and direct requests reach `irq_req` combinationally. A route write takes effect from the clock edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Route register write strobe |
| cfg_wr_addr | input | 8 | Write byte offset |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_addr | input | 8 | Read byte offset |
| cfg_rd_data | output | 8 | Read data for `cfg_rd_addr` |
| line_n | input | 8 | Shared interrupt lines A..H, active low (bit 0 = A) |
| evt_src | input | 2 | Internal event sources, active high |
| direct_irq | input | 16 | Directly driven active-high requests |
| irq_req | output | 16 | Active-high level request vector to the controller |

## Verification
The hardest case to reach from the ports is a merged target that stays asserted after one of its sources drops. This requires two or more lines, possibly including an internal event, to name the same IRQ at once while their levels change independently. Purely random route bytes rarely produce this, so the stimulus draws route targets from a small pool of three IRQs most of the time. Directed steps also aim two lines and an event at one IRQ and release them one by one. Invalid targets and set disable bits are mixed into the random writes, so R5 and R6 are exercised alongside live traffic.

// File: rtl/irq_steer_pkg.sv
// Package: shared types and constants of the steering router.
// Assumes an 8-bit route register with a disable flag in bit 7 and the
// target number in bits 3:0; bits 6:4 are stored but carry no meaning.
package irq_steer_pkg;
    typedef logic [7:0] route_t;

    localparam int unsigned ROUTE_OFF_BIT = 7;
    localparam int unsigned TGT_W         = 4;
    localparam route_t      ROUTE_RESET   = 8'h80;
endpackage

// File: rtl/steer_cfg_regs.sv
// Route register file: one byte per shared line, at two four-byte groups.
// Assumes NUM_LINES is twice a power of two and that each group base is
// aligned to its group size. Unmapped writes are dropped and unmapped
// reads return zero.
module steer_cfg_regs
    import irq_steer_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [7:0]  GRP_A_BASE = 8'h60,
    parameter logic [7:0]  GRP_B_BASE = 8'h68
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  route_t                      wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output route_t                      rd_data,
    output logic [NUM_LINES-1:0][7:0]   route_q
);
    localparam int unsigned SLOT_W = $clog2(NUM_LINES / 2);
    localparam int unsigned IDX_W  = SLOT_W + 1;

    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;
    logic             rd_hit;
    logic [IDX_W-1:0] rd_idx;

    // Decode the write offset into a line index.
    always_comb begin
        wr_hit = 1'b0;
        wr_idx = '0;
        if (wr_addr[ADDR_W-1:SLOT_W] == GRP_A_BASE[ADDR_W-1:SLOT_W]) begin
            wr_hit = 1'b1;
            wr_idx = {1'b0, wr_addr[SLOT_W-1:0]};
        end else if (wr_addr[ADDR_W-1:SLOT_W] == GRP_B_BASE[ADDR_W-1:SLOT_W]) begin
            wr_hit = 1'b1;
            wr_idx = {1'b1, wr_addr[SLOT_W-1:0]};
        end
    end

    // Decode the read offset into a line index.
    always_comb begin
        rd_hit = 1'b0;
        rd_idx = '0;
        if (rd_addr[ADDR_W-1:SLOT_W] == GRP_A_BASE[ADDR_W-1:SLOT_W]) begin
            rd_hit = 1'b1;
            rd_idx = {1'b0, rd_addr[SLOT_W-1:0]};
        end else if (rd_addr[ADDR_W-1:SLOT_W] == GRP_B_BASE[ADDR_W-1:SLOT_W]) begin
            rd_hit = 1'b1;
            rd_idx = {1'b1, rd_addr[SLOT_W-1:0]};
        end
    end

    // Return the stored byte for a mapped read, zero otherwise.
    always_comb begin
        rd_data = rd_hit ? route_q[rd_idx] : 8'h00;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_reg
        // Hold one route byte; reset to the disabled value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[g] <= ROUTE_RESET;
            else if (wr_en && wr_hit && wr_idx == IDX_W'(g))
                route_q[g] <= wr_data;
        end

        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_hit && wr_idx == IDX_W'(g)) |=> (route_q[g] == $past(wr_data)));
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(route_q));

    assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(route_q));
endmodule

// File: rtl/steer_line_cond.sv
// Line conditioning: inverts the active-low shared lines and folds each
// internal event into the line chosen for it by EVT_LINE (one byte per
// event, holding the line index). Purely combinational.
module steer_line_cond #(
    parameter int unsigned             NUM_LINES = 8,
    parameter int unsigned             NUM_EVT   = 2,
    parameter logic [NUM_EVT*8-1:0]    EVT_LINE  = 16'h0300
) (
    input  logic [NUM_LINES-1:0] line_n,
    input  logic [NUM_EVT-1:0]   evt_src,
    output logic [NUM_LINES-1:0] line_act
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Active-high level of line g, including any event aimed at it.
        always_comb begin
            line_act[g] = ~line_n[g];
            for (int e = 0; e < NUM_EVT; e++) begin
                if (EVT_LINE[e*8 +: 8] == 8'(g))
                    line_act[g] = line_act[g] | evt_src[e];
            end
        end
    end
endmodule

// File: rtl/steer_xbar.sv
// Steering crossbar: each active line is decoded to a one-hot target. A
// target is only decoded when the line's disable bit is clear and the
// target lies in ALLOWED. The one-hot vectors of all lines are then ORed.
module steer_xbar
    import irq_steer_pkg::*;
#(
    parameter int unsigned          NUM_LINES = 8,
    parameter int unsigned          NUM_IRQ   = 16,
    parameter logic [NUM_IRQ-1:0]   ALLOWED   = 16'hDEF8
) (
    input  logic [NUM_LINES-1:0]        line_act,
    input  logic [NUM_LINES-1:0][7:0]   route_q,
    output logic [NUM_IRQ-1:0]          routed
);
    logic [NUM_LINES-1:0][NUM_IRQ-1:0] dec;
    logic [NUM_LINES-1:0][2:0]         unused_mid;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        logic [TGT_W-1:0] tgt;
        assign tgt           = route_q[g][TGT_W-1:0];
        assign unused_mid[g] = route_q[g][6:4];

        // One-hot target of line g when it is active and routable.
        always_comb begin
            dec[g] = '0;
            if (line_act[g] && !route_q[g][ROUTE_OFF_BIT] && ALLOWED[tgt])
                dec[g][tgt] = 1'b1;
        end
    end

    // Wired-OR of every line's contribution.
    always_comb begin
        routed = '0;
        for (int k = 0; k < NUM_LINES; k++)
            routed = routed | dec[k];
    end
endmodule

// File: rtl/irq_steer_router.sv
// Top of the shared interrupt line steering router. Route registers are
// clocked; the request path from lines, events and direct inputs to
// irq_req is combinational. Assumes the downstream controller treats
// steered IRQs as level sensitive (software sets that up elsewhere).
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int unsigned          NUM_LINES  = 8,
    parameter int unsigned          NUM_IRQ    = 16,
    parameter int unsigned          NUM_EVT    = 2,
    parameter int unsigned          ADDR_W     = 8,
    parameter logic [7:0]           GRP_A_BASE = 8'h60,
    parameter logic [7:0]           GRP_B_BASE = 8'h68,
    parameter logic [NUM_IRQ-1:0]   ALLOWED    = 16'hDEF8,
    parameter logic [NUM_EVT*8-1:0] EVT_LINE   = 16'h0300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [ADDR_W-1:0]    cfg_wr_addr,
    input  logic [7:0]           cfg_wr_data,
    input  logic [ADDR_W-1:0]    cfg_rd_addr,
    output logic [7:0]           cfg_rd_data,
    input  logic [NUM_LINES-1:0] line_n,
    input  logic [NUM_EVT-1:0]   evt_src,
    input  logic [NUM_IRQ-1:0]   direct_irq,
    output logic [NUM_IRQ-1:0]   irq_req
);
    logic [NUM_LINES-1:0][7:0] route_q;
    logic [NUM_LINES-1:0]      line_act;
    logic [NUM_IRQ-1:0]        routed;
    logic                      all_off;

    steer_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .GRP_A_BASE(GRP_A_BASE),
        .GRP_B_BASE(GRP_B_BASE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_addr(cfg_wr_addr),
        .wr_data(cfg_wr_data),
        .rd_addr(cfg_rd_addr),
        .rd_data(cfg_rd_data),
        .route_q(route_q)
    );

    steer_line_cond #(
        .NUM_LINES(NUM_LINES),
        .NUM_EVT  (NUM_EVT),
        .EVT_LINE (EVT_LINE)
    ) u_cond (
        .line_n  (line_n),
        .evt_src (evt_src),
        .line_act(line_act)
    );

    steer_xbar #(
        .NUM_LINES(NUM_LINES),
        .NUM_IRQ  (NUM_IRQ),
        .ALLOWED  (ALLOWED)
    ) u_xbar (
        .line_act(line_act),
        .route_q (route_q),
        .routed  (routed)
    );

    // Merge routed lines with the direct requests.
    always_comb begin
        irq_req = routed | direct_irq;
    end

    // True when every route register carries its disable bit.
    always_comb begin
        all_off = 1'b1;
        for (int k = 0; k < NUM_LINES; k++)
            all_off = all_off & route_q[k][ROUTE_OFF_BIT];
    end

    assert_all_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (irq_req == direct_irq));

    assert_no_forbidden_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~ALLOWED & ~direct_irq) == '0);

    assert_direct_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & direct_irq) == direct_irq);
endmodule

// File: tb/irq_steer_router_bench.sv
`timescale 1ns/1ps
module irq_steer_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = 8'h00;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [7:0]  cfg_rd_addr = 8'h00;
    logic [7:0]  cfg_rd_data;
    logic [7:0]  line_n = 8'hFF;
    logic [1:0]  evt_src = 2'b00;
    logic [15:0] direct_irq = 16'h0000;
    logic [15:0] irq_req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [7:0] shadow [8];

    always #2.5 clk = ~clk;

    irq_steer_router u_irq_steer_router (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .line_n(line_n), .evt_src(evt_src), .direct_irq(direct_irq), .irq_req(irq_req)
    );

    // Line index of a byte offset, or -1 when unmapped (R2, R3).
    function automatic int line_of(input logic [7:0] a);
        if (a >= 8'h60 && a <= 8'h63) return int'(a - 8'h60);
        if (a >= 8'h68 && a <= 8'h6B) return 4 + int'(a - 8'h68);
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int l = line_of(a);
        return (l < 0) ? 8'h00 : shadow[l];
    endfunction

    // Expected request vector from R4..R9.
    function automatic logic [15:0] exp_irq(input logic [7:0] ln, input logic [1:0] ev,
                                            input logic [15:0] dir);
        logic [15:0] allowed = 16'b1101_1110_1111_1000;
        logic [15:0] r = dir;
        for (int k = 0; k < 8; k++) begin
            bit act = !ln[k] || (k == 0 && ev[0]) || (k == 3 && ev[1]);
            if (act && !shadow[k][7] && allowed[shadow[k][3:0]])
                r[shadow[k][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, then track writes.
    task automatic step(input string req, input logic we, input logic [7:0] wa,
                        input logic [7:0] wd, input logic [7:0] ra, input logic [7:0] ln,
                        input logic [1:0] ev, input logic [15:0] dir);
        int l;
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd; cfg_rd_addr = ra;
        line_n = ln; evt_src = ev; direct_irq = dir;
        #1;
        check({req, " irq"}, irq_req, exp_irq(ln, ev, dir));
        check({req, " rd"}, {8'h00, cfg_rd_data}, {8'h00, exp_read(ra)});
        @(posedge clk);
        l = line_of(wa);
        if (we && l >= 0) shadow[l] = wd;
    endtask

    function automatic logic [7:0] addr_of(input int l);
        return (l < 4) ? 8'(8'h60 + l) : 8'(8'h68 + l - 4);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 8; k++) shadow[k] = 8'h80;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values and quiet output with all lines low.
        for (int k = 0; k < 8; k++)
            step("R1", 1'b0, 8'h00, 8'h00, addr_of(k), 8'h00, 2'b11, 16'h0000);

        // R2 and R10: write A -> IRQ5 with line A low; effect only after the edge.
        step("R10", 1'b1, 8'h60, 8'h05, 8'h60, 8'hFE, 2'b00, 16'h0);
        step("R4",  1'b0, 8'h00, 8'h00, 8'h60, 8'hFE, 2'b00, 16'h0);
        step("R2",  1'b1, 8'h6B, 8'h7C, 8'h6B, 8'hFF, 2'b00, 16'h0);
        step("R2",  1'b0, 8'h00, 8'h00, 8'h6B, 8'h7F, 2'b00, 16'h0);

        // R3: unmapped writes ignored, unmapped reads zero.
        step("R3", 1'b1, 8'h64, 8'h03, 8'h64, 8'hFF, 2'b00, 16'h0);
        step("R3", 1'b1, 8'h5F, 8'h03, 8'h6C, 8'hFF, 2'b00, 16'h0);
        for (int k = 0; k < 8; k++)
            step("R3", 1'b0, 8'h00, 8'h00, addr_of(k), 8'h00, 2'b00, 16'h0);

        // R5: disable bit wins over a valid target.
        step("R5", 1'b1, 8'h60, 8'h85, 8'h60, 8'hFE, 2'b00, 16'h0);
        step("R5", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFE, 2'b00, 16'h0);

        // R6: forbidden targets act as disabled.
        step("R6", 1'b1, 8'h61, 8'h02, 8'h61, 8'hFD, 2'b00, 16'h0);
        step("R6", 1'b1, 8'h61, 8'h08, 8'h61, 8'hFD, 2'b00, 16'h0);
        step("R6", 1'b1, 8'h61, 8'h0D, 8'h61, 8'hFD, 2'b00, 16'h0);
        step("R6", 1'b1, 8'h61, 8'h00, 8'h61, 8'hFD, 2'b00, 16'h0);
        step("R6", 1'b0, 8'h00, 8'h00, 8'h61, 8'hFD, 2'b00, 16'h0);

        // R7 and R8: A, B and D all on IRQ10; release one source at a time.
        step("R7", 1'b1, 8'h60, 8'h0A, 8'h60, 8'hFF, 2'b00, 16'h0);
        step("R7", 1'b1, 8'h61, 8'h0A, 8'h61, 8'hFF, 2'b00, 16'h0);
        step("R8", 1'b1, 8'h63, 8'h0A, 8'h63, 8'hFF, 2'b00, 16'h0);
        step("R7", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFC, 2'b10, 16'h0);
        step("R7", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFD, 2'b10, 16'h0);
        step("R8", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFF, 2'b10, 16'h0);
        step("R8", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFF, 2'b00, 16'h0);
        step("R8", 1'b1, 8'h60, 8'h0E, 8'h60, 8'hFF, 2'b01, 16'h0);
        step("R8", 1'b0, 8'h00, 8'h00, 8'h60, 8'hFF, 2'b01, 16'h0);

        // R9: direct requests pass through, including forbidden numbers.
        step("R9", 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 2'b00, 16'h2107);
        step("R9", 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 16'hFFFF);

        // Random mix of writes, reads, line levels, events and direct bits (R4..R9).
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] wa, wd, ra;
            int sel = int'($urandom_range(0, 9));
            wa = (sel < 8) ? addr_of(sel) : 8'($urandom);
            ra = ($urandom_range(0, 4) == 0) ? 8'($urandom) : addr_of(int'($urandom_range(0, 7)));
            case ($urandom_range(0, 5))
                0:       wd = 8'($urandom);
                1:       wd = {1'b1, 3'($urandom), 4'($urandom)};
                default: wd = {4'h0, (($urandom_range(0, 2) == 0) ? 4'd4 :
                                      ($urandom_range(0, 1) == 0) ? 4'd11 : 4'd15)};
            endcase
            step("R7", ($urandom_range(0, 2) == 0), wa, wd, ra, 8'($urandom),
                 2'($urandom), ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule